// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Port

This block is the digital output stage of a slow delta-sigma converter. It waits for the converter core to report a finished conversion, places the result into a fixed 24-bit output word, and serves that word over a three-pin serial link: a data line, a clock line and an optional active-low select. The converter core is outside the block. It sees a start pulse from this port and later returns a result together with a one-cycle done strobe.

The clock line can run in either direction. If the host holds the clock low when the power-on interval after reset ends, the host supplies the clock, and the select may stay low for good, so that two wires are enough. If the clock line reads high when the select falls (a modelled weak pull-up makes an undriven pin read high), the port drives the clock itself from a divided system clock. Between reads, the data line carries a live flag: high while a conversion runs, low once a result is waiting. After the last of the 24 bits, the line stays high, so a host that sends 32 clocks reads ones in the extra slots.

All pin inputs are brought into one system clock domain through two flip-flops. Edges on the select and clock pins are found from these synchronised values.

Top module: `adc_serial_port`

## Requirements
- R1: From reset until POR_CYCLES system clocks have passed, sdo_oe, sck_oe and conv_start stay low. At the end of that interval, one single-cycle conv_start pulse is issued, no later than POR_CYCLES+4 clocks after reset is released.
- R2: If the clock pin reads low when the power-on interval ends, the port uses a host-supplied clock and never asserts sck_oe in that mode.
- R3: While the select pin is high, sdo_oe is low (data line high-impedance). While it is low and the power-on interval is over, sdo_oe is high.
- R4: Outside a read, with the select low, sdo_out is 1 while a conversion is in progress and 0 once a result is waiting.
- R5: The word is sent most significant bit first. Bit 23 is the ready flag and is 0. Bit 22 is 0. Bit 21 is conv_result[17] (sign). Bits 20 down to 4 are conv_result[16:0]. Bits 3 down to 0 are 0.
- R6: With a host clock, bit 23 is on sdo_out before the first rising clock edge, and each falling edge moves sdo_out on to the next lower bit.
- R7: The 24th falling clock edge of a read sets sdo_out to 1 and issues one conv_start pulse.
- R8: Clock edges that arrive while a conversion runs do not move the read position. sdo_out stays 1 for each of them, and the next read starts again at bit 23.
- R9: The result is captured only when the done strobe arrives during a conversion. A done strobe during a read leaves the word being sent unchanged.
- R10: A falling select with the clock pin high or undriven selects the internal clock. A falling select with the clock pin held low selects the host clock.
- R11: With the internal clock and the select low, the port drives the clock low (sck_oe=1, sck_out=0) while a conversion runs. Once a result is waiting, it sends 24 pulses, each high for SCK_DIV and low for SCK_DIV system clocks, with data changing on falling edges. It then drops sck_oe and issues conv_start.
- R12: With the select tied low, the host-clock mode works with only the clock and data pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; the power-on interval starts when it is released |
| conv_result | input | MAG_W+1 | Result from the core: sign in the top bit, magnitude below it |
| conv_done | input | 1 | One-cycle strobe from the core that conv_result is valid |
| sck_in | input | 1 | Level sampled from the clock pin |
| cs_n_in | input | 1 | Level sampled from the active-low select pin |
| sdo_out | output | 1 | Serial data / ready flag value |
| sdo_oe | output | 1 | Drive enable for the data pin |
| sck_out | output | 1 | Clock value driven in internal-clock mode |
| sck_oe | output | 1 | Drive enable for the clock pin |
| conv_start | output | 1 | One-cycle pulse that starts a new conversion |

## Verification
The read path is exercised with three result words: alternating bits with a negative sign, a zero result, and a full-scale magnitude with a positive sign. These separate a misplaced sign bit, a shifted magnitude field and nonzero padding. The reads use a host clock with the select tied low, an internally generated clock entered while a conversion is still running, and a host clock again after the mode switches back, so mode selection is seen from both the power-on path and the select-edge path. Extra host clocks during a conversion and a stray done strobe in the middle of a read check that neither one disturbs the frame alignment or the word being sent.

// File: rtl/adc_port_pkg.sv
package adc_port_pkg;
   typedef enum logic {
      MODE_EXT = 1'b0,
      MODE_INT = 1'b1
   } clk_mode_e;

   localparam int DEF_FRAME_W = 24;
   localparam int DEF_MAG_W   = 17;
   localparam int DEF_MAG_LSB = 4;
endpackage

// File: rtl/adc_pin_sync.sv
module adc_pin_sync #(
   parameter int            W       = 2,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] st;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adc_pin_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= {STAGES{RST_VAL}};
      else        st <= {st[STAGES-2:0], d};
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/adc_por_timer.sv
module adc_por_timer #(
   parameter int POR_CYCLES = 64
) (
   input  logic clk,
   input  logic rst_n,
   output logic por_done,
   output logic por_end
);
   localparam int PW = $clog2(POR_CYCLES + 1);

   logic [PW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt <= '0;
      else if (cnt != PW'(POR_CYCLES))     cnt <= cnt + PW'(1);
   end

   assign por_done = (cnt == PW'(POR_CYCLES));
   assign por_end  = (cnt == PW'(POR_CYCLES - 1));
endmodule

// File: rtl/adc_sck_gen.sv
module adc_sck_gen #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic sck,
   output logic fall
);
   localparam int DW = $clog2(DIV + 1);

   logic [DW-1:0] cnt;
   logic          wrap;

   assign wrap = (cnt == DW'(DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (!en) begin
         cnt <= '0;
         sck <= 1'b0;
      end else if (wrap) begin
         cnt <= '0;
         sck <= ~sck;
      end else begin
         cnt <= cnt + DW'(1);
      end
   end

   assign fall = en & sck & wrap;
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
   import adc_port_pkg::*;
#(
   parameter int FRAME_W    = DEF_FRAME_W,
   parameter int MAG_W      = DEF_MAG_W,
   parameter int MAG_LSB    = DEF_MAG_LSB,
   parameter int POR_CYCLES = 64,
   parameter int SCK_DIV    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [MAG_W:0]   conv_result,
   input  logic             conv_done,
   input  logic             sck_in,
   input  logic             cs_n_in,
   output logic             sdo_out,
   output logic             sdo_oe,
   output logic             sck_out,
   output logic             sck_oe,
   output logic             conv_start
);
   localparam int SIGN_POS = MAG_LSB + MAG_W;
   localparam int CNT_W    = $clog2(FRAME_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);

   generate
      if (SIGN_POS >= FRAME_W - 1) begin : g_bad_layout
         $error("adc_serial_port: sign field collides with the ready flag");
      end
      if (SCK_DIV < 1) begin : g_bad_div
         $error("adc_serial_port: SCK_DIV must be at least 1");
      end
      if (POR_CYCLES < 4) begin : g_bad_por
         $error("adc_serial_port: POR_CYCLES must cover the pin synchroniser");
      end
   endgenerate

   // pin synchronisers and edge detection
   logic [1:0] pin_s;
   logic       cs_s, sck_s, cs_prev, sck_prev;
   logic       cs_low, cs_fall, sck_fall_ext;

   adc_pin_sync #(.W(2), .STAGES(2), .RST_VAL(2'b11)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n_in, sck_in}), .q(pin_s)
   );

   assign cs_s = pin_s[1];
   assign sck_s = pin_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev  <= 1'b1;
         sck_prev <= 1'b1;
      end else begin
         cs_prev  <= cs_s;
         sck_prev <= sck_s;
      end
   end

   assign cs_low       = ~cs_s;
   assign cs_fall      = cs_prev & ~cs_s;
   assign sck_fall_ext = sck_prev & ~sck_s;

   // power-on interval
   logic por_done, por_end;

   adc_por_timer #(.POR_CYCLES(POR_CYCLES)) u_por (
      .clk(clk), .rst_n(rst_n), .por_done(por_done), .por_end(por_end)
   );

   // clock direction
   clk_mode_e mode_q;
   logic      int_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mode_q <= MODE_INT;
      else if (por_end)                 mode_q <= sck_s ? MODE_INT : MODE_EXT;
      else if (por_done && cs_fall)     mode_q <= sck_s ? MODE_INT : MODE_EXT;
   end

   assign int_mode = (mode_q == MODE_INT);

   // output word layout
   logic [FRAME_W-1:0] frame_w;

   always_comb begin
      frame_w = '0;
      frame_w[MAG_LSB +: MAG_W] = conv_result[MAG_W-1:0];
      frame_w[SIGN_POS]         = conv_result[MAG_W];
   end

   // conversion / read sequencing
   logic               busy, released;
   logic [FRAME_W-1:0] sr;
   logic [CNT_W-1:0]   bit_cnt;
   logic               gen_en, gen_fall, fall_evt, read_ok;

   assign read_ok  = por_done & ~busy & cs_low;
   assign fall_evt = int_mode ? gen_fall : sck_fall_ext;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy       <= 1'b1;
         released   <= 1'b0;
         sr         <= '1;
         bit_cnt    <= '0;
         conv_start <= 1'b0;
      end else begin
         conv_start <= 1'b0;
         if (por_end) begin
            busy       <= 1'b1;
            conv_start <= 1'b1;
         end else if (busy && por_done && conv_done) begin
            sr      <= frame_w;
            busy    <= 1'b0;
            bit_cnt <= '0;
         end else if (read_ok && fall_evt) begin
            sr <= {sr[FRAME_W-2:0], 1'b1};
            if (bit_cnt == LAST_BIT) begin
               bit_cnt    <= '0;
               busy       <= 1'b1;
               conv_start <= 1'b1;
               released   <= int_mode;
            end else begin
               bit_cnt <= bit_cnt + CNT_W'(1);
            end
         end
         if (!cs_low) released <= 1'b0;
      end
   end

   // pin drive
   assign sdo_oe  = por_done & cs_low;
   assign sdo_out = busy ? 1'b1 : sr[FRAME_W-1];
   assign sck_oe  = por_done & int_mode & cs_low & ~cs_fall & ~released;
   assign gen_en  = sck_oe & ~busy;

   adc_sck_gen #(.DIV(SCK_DIV)) u_sck (
      .clk(clk), .rst_n(rst_n), .en(gen_en), .sck(sck_out), .fall(gen_fall)
   );
endmodule

// File: rtl/adc_serial_port_chk.sv
module adc_serial_port_chk #(
   parameter int CNT_W   = 5,
   parameter int FRAME_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n_in,
   input logic             sdo_out,
   input logic             sdo_oe,
   input logic             sck_out,
   input logic             sck_oe,
   input logic             conv_start,
   input logic             busy,
   input logic             int_mode,
   input logic             por_done,
   input logic [CNT_W-1:0] bit_cnt
);
   p_quiet_por_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !por_done |-> (!sdo_oe && !sck_oe && !conv_start));

   p_ext_no_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (por_done && !int_mode) |-> !sck_oe);

   p_hiz_cs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n_in && $past(cs_n_in) && $past(cs_n_in, 2) && $past(cs_n_in, 3)) |-> !sdo_oe);

   p_flag_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sdo_oe && busy) |-> sdo_out);

   p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt < CNT_W'(FRAME_W));

   p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);

   p_start_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   p_sck_with_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> sdo_oe);

   p_sck_low_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sck_oe && busy) |-> !sck_out);
endmodule

bind adc_serial_port adc_serial_port_chk #(.CNT_W(CNT_W), .FRAME_W(FRAME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n_in), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
   .sck_out(sck_out), .sck_oe(sck_oe), .conv_start(conv_start), .busy(busy),
   .int_mode(int_mode), .por_done(por_done), .bit_cnt(bit_cnt)
);

// File: tb/sim_adc_serial_port.sv
`timescale 1ns/1ps
module sim_adc_serial_port;
   localparam int POR  = 32;
   localparam int DIV  = 4;
   localparam int HP   = 8;
   localparam int CONV = 400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [17:0] next_result = '0;
   logic        core_done = 1'b0, extra_done = 1'b0, conv_done;
   logic        cs_n = 1'b0, host_en = 1'b1, host_sck = 1'b0, sck_pin;
   logic        sdo_out, sdo_oe, sck_out, sck_oe, conv_start;
   int          checks = 0, fails = 0, starts = 0, ccnt = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   assign sck_pin   = sck_oe ? sck_out : (host_en ? host_sck : 1'b1);
   assign conv_done = core_done | extra_done;

   adc_serial_port #(.POR_CYCLES(POR), .SCK_DIV(DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .conv_result(next_result), .conv_done(conv_done),
      .sck_in(sck_pin), .cs_n_in(cs_n), .sdo_out(sdo_out), .sdo_oe(sdo_oe),
      .sck_out(sck_out), .sck_oe(sck_oe), .conv_start(conv_start)
   );

   // converter core model: fixed conversion time after each start pulse
   always @(posedge clk) begin
      core_done <= 1'b0;
      if (conv_start) starts <= starts + 1;
      if (conv_start) ccnt <= CONV;
      else if (ccnt != 0) begin
         ccnt <= ccnt - 1;
         if (ccnt == 1) core_done <= 1'b1;
      end
   end

   function automatic logic [23:0] exp_frame(input logic [17:0] r);
      return {1'b0, 1'b0, r[17], r[16:0], 4'b0000};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wait_ready(input string req);
      int n = 0;
      @(negedge clk);
      while (sdo_out !== 1'b0 && n < CONV + 100) begin
         @(negedge clk);
         n++;
      end
      repeat (2) @(negedge clk);
      chk(req, {31'd0, sdo_out}, 32'd0);
   endtask

   task automatic host_read(input logic [17:0] res, input string req);
      logic [23:0] got = '0;
      int s0 = starts;
      for (int i = 0; i < 24; i++) begin
         got[23 - i] = sdo_out;
         host_sck = 1'b1;
         repeat (HP) @(negedge clk);
         host_sck = 1'b0;
         repeat (HP) @(negedge clk);
      end
      chk({req, " frame"}, {8'd0, got}, {8'd0, exp_frame(res)});
      chk("R7 sdo high after 24th edge", {31'd0, sdo_out}, 32'd1);
      chk("R7 one start pulse", starts - s0, 32'd1);
   endtask

   task automatic t_reset();
      int n = 0;
      rst_n = 1'b0; cs_n = 1'b0; host_en = 1'b1; host_sck = 1'b0;
      next_result = 18'h2AAAA;
      repeat (5) @(negedge clk);
      chk("R1 quiet in reset", {29'd0, sdo_oe, sck_oe, conv_start}, 32'd0);
      rst_n = 1'b1;
      while (!conv_start && n < POR + 20) begin
         @(negedge clk);
         n++;
         if (!conv_start) checks += 0;
      end
      chk("R1 start after power-on", {31'd0, (n >= POR - 1) && (n <= POR + 4)}, 32'd1);
      repeat (3) @(negedge clk);
      chk("R12 data driven with select tied low", {31'd0, sdo_oe}, 32'd1);
      chk("R4 flag high while converting", {31'd0, sdo_out}, 32'd1);
      chk("R2 host clock mode, no clock drive", {31'd0, sck_oe}, 32'd0);
      wait_ready("R4 flag low when ready");
   endtask

   task automatic t_ext_read();
      logic [17:0] a = next_result;
      next_result = 18'h00000;
      host_read(a, "R5 R6 R12 alternating negative");
   endtask

   task automatic t_extra_clocks();
      int ones = 0;
      for (int i = 0; i < 8; i++) begin
         host_sck = 1'b1;
         repeat (HP) @(negedge clk);
         ones += sdo_out;
         host_sck = 1'b0;
         repeat (HP) @(negedge clk);
         ones += sdo_out;
      end
      chk("R8 ones during extra clocks", ones, 32'd16);
      wait_ready("R8 ready after extra clocks");
      next_result = 18'h1FFFF;
      host_read(18'h00000, "R8 R5 realigned zero word");
   endtask

   task automatic t_stray_done();
      logic [23:0] got = '0;
      wait_ready("R4 ready before stray strobe");
      for (int i = 0; i < 24; i++) begin
         got[23 - i] = sdo_out;
         if (i == 10) begin
            next_result = 18'h3C3C3;
            extra_done = 1'b1;
            @(negedge clk);
            extra_done = 1'b0;
            next_result = 18'h15555;
         end
         host_sck = 1'b1;
         repeat (HP) @(negedge clk);
         host_sck = 1'b0;
         repeat (HP) @(negedge clk);
      end
      chk("R9 word kept across stray strobe", {8'd0, got}, {8'd0, exp_frame(18'h1FFFF)});
   endtask

   task automatic t_cs_hiz();
      cs_n = 1'b1;
      repeat (5) @(negedge clk);
      chk("R3 data released with select high", {31'd0, sdo_oe}, 32'd0);
   endtask

   task automatic t_internal();
      logic [23:0] got = '0;
      int n = 0, t = 0, hi = 0, badw = 0, s0;
      logic prev;
      host_en = 1'b0;
      repeat (3) @(negedge clk);
      cs_n = 1'b0;
      repeat (5) @(negedge clk);
      chk("R10 internal clock chosen", {31'd0, sck_oe}, 32'd1);
      chk("R11 clock held low while converting", {30'd0, sck_out, sdo_out}, 32'd1);
      s0 = starts;
      prev = sck_out;
      while (n < 24 && t < CONV + 1000) begin
         @(negedge clk);
         t++;
         if (!prev && sck_out) begin
            got[23 - n] = sdo_out;
            hi = 0;
         end
         if (sck_out) hi++;
         if (prev && !sck_out) begin
            if (hi != DIV) badw++;
            n++;
         end
         prev = sck_out;
      end
      chk("R11 pulse count", n, 32'd24);
      chk("R11 pulse width", badw, 32'd0);
      chk("R11 R5 internal frame", {8'd0, got}, {8'd0, exp_frame(18'h15555)});
      repeat (3) @(negedge clk);
      chk("R11 clock released, flag high", {30'd0, sck_oe, sdo_out}, 32'd1);
      chk("R11 start after internal read", starts - s0, 32'd1);
   endtask

   task automatic t_back_to_ext();
      int drv = 0;
      cs_n = 1'b1;
      host_en = 1'b1;
      host_sck = 1'b0;
      repeat (5) @(negedge clk);
      cs_n = 1'b0;
      for (int i = 0; i < CONV + 20; i++) begin
         @(negedge clk);
         drv += sck_oe;
      end
      chk("R10 host clock chosen on select edge", drv, 32'd0);
      chk("R4 ready in host mode", {31'd0, sdo_out}, 32'd0);
      host_read(18'h15555, "R10 R5 host read after switch");
   endtask

   initial begin
      t_reset();
      t_ext_read();
      t_extra_clocks();
      t_stray_done();
      t_cs_hiz();
      t_internal();
      t_back_to_ext();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule